// File: doc/BRIEF.md
# Secure System-Register Space Router

This block decodes and filters accesses into the 1 MB private system-register region that starts at 0xE000_0000. It takes one request at a time from a CPU bus port that carries a secure attribute and a user (unprivileged) attribute. It then does one of two things with the request. It can hand the request to one of several register-bank target ports: the main control space, a secure timer bank, a non-secure timer bank, or an optional debug/RAS bank. Otherwise it answers the request itself through a built-in default responder. The request address is the 20-bit offset inside the region.

Several windows overlap, and they resolve by priority. The timer window and the RAS window take precedence over the control space. The control space takes precedence over the default responder. When the security extension is built in, a non-secure alias window exists. Secure accesses to it are passed on to the matching main target with the secure attribute cleared. Non-secure accesses to it are answered locally. A target's read data and error bit travel back to the CPU unchanged. Only one transaction is outstanding at a time.

Top module: `sysreg_router`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and no bit of tgt_valid is set.
- R2: Offsets 0x0E010 to 0x0E0EF (the timer window) are forwarded with tgt_addr = offset − 0x0E010, even though they lie inside the control space. A secure access goes to target index 2 (secure timer bank). A non-secure access goes to index 1 (non-secure timer bank).
- R3: Offsets 0x0E000 to 0x0EFFF that are outside the timer window go to target index 0 (control space) with tgt_addr = offset − 0x0E000.
- R4: With RAS_EN = 1, offsets 0x05000 to 0x05FFF go to target index 3 with tgt_addr = offset − 0x05000. With RAS_EN = 0, these offsets fall to the default responder.
- R5: The default responder handles every unclaimed offset and every req_size code (0 to 3 meaning 1, 2, 4 or 8 bytes). A privileged access gets rsp_rdata = 0 and rsp_err = 0, and a write changes nothing. A user access gets rsp_err = 1 and rsp_rdata = 0. No target is touched, and rsp_valid follows one cycle after acceptance.
- R6: With SEC_EN = 1, a secure access to the alias window 0x2E000 to 0x2EFFF is forwarded with tgt_secure = 0. Its timer part, 0x2E010 to 0x2E0EF, goes to index 1 with tgt_addr = offset − 0x2E010. The rest goes to index 0 with tgt_addr = offset − 0x2E000.
- R7: A non-secure access to the alias window is never forwarded. It reads as zero with no error if privileged, and returns rsp_err = 1 if user.
- R8: With SEC_EN = 0, the alias window is handled by the default responder, and index 2 is never selected. Every timer-window access goes to index 1.
- R9: A forwarded request keeps req_write, req_wdata, req_size and req_user unchanged. The target's read data and error bit come back unchanged on a single-cycle rsp_valid, one cycle after the selected target raises tgt_rsp_valid.
- R10: req_ready is low from the acceptance edge until the cycle after rsp_valid. Each forwarded transaction raises exactly one tgt_valid bit, for exactly one cycle.
- R11: A tgt_rsp_valid from a target other than the selected one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Router idle; request accepted on this edge |
| req_addr | input | ADDR_W | Offset inside the 1 MB region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_size | input | 2 | log2 of access bytes (0..3) |
| req_secure | input | 1 | Secure attribute |
| req_user | input | 1 | Unprivileged attribute |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Bus error |
| tgt_valid | output | 4 | One-hot request strobe per target |
| tgt_addr | output | OFF_W | Offset inside the selected target window |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_wdata | output | DATA_W | Forwarded write data |
| tgt_size | output | 2 | Forwarded size code |
| tgt_secure | output | 1 | Forwarded secure attribute |
| tgt_user | output | 1 | Forwarded user attribute |
| tgt_rsp_valid | input | 4 | Response strobe from each target |
| tgt_rsp_rdata | input | 4*DATA_W | Read data of each target, index k in slice k |
| tgt_rsp_err | input | 4 | Error bit of each target |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-hot, single-cycle request strobe and the one-cycle response pulse. They also cover the busy interval of req_ready, the zero-data local answer with its error bit, the unchanged copy of the forwarded fields, and the rule that a non-selected response cannot end a wait. Other behaviour needs the bench's scenarios. These include the exact window edges and the priority of the timer window over the control space. They also include the banking by the secure attribute, the clearing of that attribute in the alias, and the spurious responses from other targets. A second instance built without the security extension and without the RAS window shows the fall-through to the default responder.

// File: rtl/sysreg_pkg.sv
`timescale 1ns/1ps
package sysreg_pkg;
  localparam int unsigned NUM_TGT   = 4;
  localparam int unsigned TGT_IDX_W = 2;

  localparam logic [TGT_IDX_W-1:0] TGT_CTL    = 2'd0;
  localparam logic [TGT_IDX_W-1:0] TGT_TIM_NS = 2'd1;
  localparam logic [TGT_IDX_W-1:0] TGT_TIM_S  = 2'd2;
  localparam logic [TGT_IDX_W-1:0] TGT_RAS    = 2'd3;

  typedef enum logic [1:0] {
    ACT_FWD  = 2'd0,
    ACT_RAZ  = 2'd1,
    ACT_BERR = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } state_e;
endpackage

// File: rtl/sysreg_decode.sv
`timescale 1ns/1ps
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned SEC_EN     = 1,
  parameter int unsigned RAS_EN     = 1,
  parameter int unsigned CTL_BASE   = 'h0E000,
  parameter int unsigned CTL_SIZE   = 'h1000,
  parameter int unsigned TIM_BASE   = 'h0E010,
  parameter int unsigned TIM_SIZE   = 'hE0,
  parameter int unsigned RAS_BASE   = 'h05000,
  parameter int unsigned RAS_SIZE   = 'h1000,
  parameter int unsigned ALIAS_BASE = 'h2E000
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 secure,
  input  logic                 user,
  output act_e                 act,
  output logic [TGT_IDX_W-1:0] tgt,
  output logic [OFF_W-1:0]     off,
  output logic                 fwd_secure
);
  localparam logic [ADDR_W-1:0] CTL_LO = ADDR_W'(CTL_BASE);
  localparam logic [ADDR_W-1:0] CTL_HI = ADDR_W'(CTL_BASE + CTL_SIZE);
  localparam logic [ADDR_W-1:0] TIM_LO = ADDR_W'(TIM_BASE);
  localparam logic [ADDR_W-1:0] TIM_HI = ADDR_W'(TIM_BASE + TIM_SIZE);
  localparam logic [ADDR_W-1:0] RAS_LO = ADDR_W'(RAS_BASE);
  localparam logic [ADDR_W-1:0] RAS_HI = ADDR_W'(RAS_BASE + RAS_SIZE);
  localparam logic [ADDR_W-1:0] AL_LO  = ADDR_W'(ALIAS_BASE);
  localparam logic [ADDR_W-1:0] AL_HI  = ADDR_W'(ALIAS_BASE + CTL_SIZE);
  localparam logic [ADDR_W-1:0] ALT_LO = ADDR_W'(ALIAS_BASE + TIM_BASE - CTL_BASE);
  localparam logic [ADDR_W-1:0] ALT_HI = ADDR_W'(ALIAS_BASE + TIM_BASE - CTL_BASE + TIM_SIZE);

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  logic hit_tim, hit_ctl, hit_ras, hit_al, hit_alt, tim_bank_s;

  assign hit_tim = in_win(addr, TIM_LO, TIM_HI);
  assign hit_ctl = in_win(addr, CTL_LO, CTL_HI);

  generate
    if (RAS_EN != 0) begin : g_ras
      assign hit_ras = in_win(addr, RAS_LO, RAS_HI);
    end else begin : g_no_ras
      assign hit_ras = 1'b0;
    end

    if (SEC_EN != 0) begin : g_sec
      assign hit_al     = in_win(addr, AL_LO, AL_HI);
      assign hit_alt    = in_win(addr, ALT_LO, ALT_HI);
      assign tim_bank_s = secure;
    end else begin : g_no_sec
      assign hit_al     = 1'b0;
      assign hit_alt    = 1'b0;
      assign tim_bank_s = 1'b0;
    end
  endgenerate

  // Priority: timer / RAS (1) > control space (0) > alias handling > default (-1)
  always_comb begin
    act        = ACT_RAZ;
    tgt        = TGT_CTL;
    off        = '0;
    fwd_secure = secure;
    if (hit_tim) begin
      act = ACT_FWD;
      tgt = tim_bank_s ? TGT_TIM_S : TGT_TIM_NS;
      off = OFF_W'(addr - TIM_LO);
    end else if (hit_ras) begin
      act = ACT_FWD;
      tgt = TGT_RAS;
      off = OFF_W'(addr - RAS_LO);
    end else if (hit_ctl) begin
      act = ACT_FWD;
      tgt = TGT_CTL;
      off = OFF_W'(addr - CTL_LO);
    end else if (hit_al && secure) begin
      act        = ACT_FWD;
      fwd_secure = 1'b0;
      if (hit_alt) begin
        tgt = TGT_TIM_NS;
        off = OFF_W'(addr - ALT_LO);
      end else begin
        tgt = TGT_CTL;
        off = OFF_W'(addr - AL_LO);
      end
    end else begin
      act = user ? ACT_BERR : ACT_RAZ;
    end
  end
endmodule

// File: rtl/sysreg_rsp_mux.sv
`timescale 1ns/1ps
module sysreg_rsp_mux
  import sysreg_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [TGT_IDX_W-1:0]      sel,
  input  logic [NUM_TGT-1:0]        rsp_valid,
  input  logic [NUM_TGT*DATA_W-1:0] rsp_rdata,
  input  logic [NUM_TGT-1:0]        rsp_err,
  output logic                      valid,
  output logic [DATA_W-1:0]         rdata,
  output logic                      err
);
  logic [NUM_TGT-1:0] pick;
  logic [DATA_W-1:0]  masked [NUM_TGT];

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_tgt
    assign pick[k]   = rsp_valid[k] && (sel == TGT_IDX_W'(k));
    assign masked[k] = pick[k] ? rsp_rdata[k*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    valid = |pick;
    err   = |(pick & rsp_err);
    rdata = '0;
    for (int k = 0; k < NUM_TGT; k++) rdata = rdata | masked[k];
  end
endmodule

// File: rtl/sysreg_router.sv
`timescale 1ns/1ps
module sysreg_router
  import sysreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned SEC_EN     = 1,
  parameter int unsigned RAS_EN     = 1,
  parameter int unsigned CTL_BASE   = 'h0E000,
  parameter int unsigned CTL_SIZE   = 'h1000,
  parameter int unsigned TIM_BASE   = 'h0E010,
  parameter int unsigned TIM_SIZE   = 'hE0,
  parameter int unsigned RAS_BASE   = 'h05000,
  parameter int unsigned RAS_SIZE   = 'h1000,
  parameter int unsigned ALIAS_BASE = 'h2E000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic [1:0]                req_size,
  input  logic                      req_secure,
  input  logic                      req_user,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_err,
  output logic [NUM_TGT-1:0]        tgt_valid,
  output logic [OFF_W-1:0]          tgt_addr,
  output logic                      tgt_write,
  output logic [DATA_W-1:0]         tgt_wdata,
  output logic [1:0]                tgt_size,
  output logic                      tgt_secure,
  output logic                      tgt_user,
  input  logic [NUM_TGT-1:0]        tgt_rsp_valid,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rsp_rdata,
  input  logic [NUM_TGT-1:0]        tgt_rsp_err
);
  state_e               state;
  logic [TGT_IDX_W-1:0] sel_q;
  act_e                 dec_act;
  logic [TGT_IDX_W-1:0] dec_tgt;
  logic [OFF_W-1:0]     dec_off;
  logic                 dec_fsec;
  logic                 mux_valid, mux_err;
  logic [DATA_W-1:0]    mux_rdata;

  sysreg_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEC_EN(SEC_EN), .RAS_EN(RAS_EN),
    .CTL_BASE(CTL_BASE), .CTL_SIZE(CTL_SIZE), .TIM_BASE(TIM_BASE),
    .TIM_SIZE(TIM_SIZE), .RAS_BASE(RAS_BASE), .RAS_SIZE(RAS_SIZE),
    .ALIAS_BASE(ALIAS_BASE)
  ) u_dec (
    .addr(req_addr), .secure(req_secure), .user(req_user),
    .act(dec_act), .tgt(dec_tgt), .off(dec_off), .fwd_secure(dec_fsec)
  );

  sysreg_rsp_mux #(.DATA_W(DATA_W)) u_mux (
    .sel(sel_q), .rsp_valid(tgt_rsp_valid), .rsp_rdata(tgt_rsp_rdata),
    .rsp_err(tgt_rsp_err), .valid(mux_valid), .rdata(mux_rdata), .err(mux_err)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sel_q      <= '0;
      tgt_valid  <= '0;
      tgt_addr   <= '0;
      tgt_write  <= 1'b0;
      tgt_wdata  <= '0;
      tgt_size   <= '0;
      tgt_secure <= 1'b0;
      tgt_user   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          rsp_valid <= 1'b0;
          if (req_valid) begin
            sel_q      <= dec_tgt;
            tgt_addr   <= dec_off;
            tgt_write  <= req_write;
            tgt_wdata  <= req_wdata;
            tgt_size   <= req_size;
            tgt_secure <= dec_fsec;
            tgt_user   <= req_user;
            if (dec_act == ACT_FWD) begin
              tgt_valid <= NUM_TGT'(1) << dec_tgt;
              state     <= ST_FWD;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
              rsp_err   <= (dec_act == ACT_BERR);
              state     <= ST_RESP;
            end
          end
        end
        ST_FWD, ST_WAIT: begin
          tgt_valid <= '0;
          if (mux_valid) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mux_rdata;
            rsp_err   <= mux_err;
            state     <= ST_RESP;
          end else begin
            state <= ST_WAIT;
          end
        end
        default: begin
          rsp_valid <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R10: at most one target strobe, and only for one cycle
  a_r10_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(tgt_valid));
  a_r10_single_issue: assert property (@(posedge clk) disable iff (rst)
    (|tgt_valid) |=> (tgt_valid == '0));
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R9: response is a one-cycle pulse; forwarded fields unchanged
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid);
  a_r9_fields_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && dec_act == ACT_FWD) |=>
      (tgt_write == $past(req_write) && tgt_wdata == $past(req_wdata) &&
       tgt_size == $past(req_size) && tgt_user == $past(req_user)));
  // R5 / R7: local answer next cycle, zero data, no target touched
  a_r5_local_answer: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && dec_act != ACT_FWD) |=>
      (rsp_valid && rsp_rdata == '0 && tgt_valid == '0 &&
       rsp_err == $past(dec_act == ACT_BERR)));
  // R11: a wait cannot end without the selected target answering
  a_r11_ignore_others: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !tgt_rsp_valid[sel_q]) |=> !rsp_valid);

  generate
    if (SEC_EN == 0) begin : g_chk_nosec
      // R8: secure timer bank never selected without the security extension
      a_r8_no_secure_bank: assert property (@(posedge clk) disable iff (rst)
        !tgt_valid[TGT_TIM_S]);
    end
  endgenerate
endmodule

// File: tb/tb_sysreg_router.sv
`timescale 1ns/1ps
module tb_sysreg_router;
  import sysreg_pkg::*;
  localparam int AW = 20;
  localparam int DW = 64;
  localparam int OW = 12;
  localparam int NT = 4;
  localparam int RAZ = 4;
  localparam int BERR = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_size  = '0;
  logic          req_secure = 1'b0, req_user = 1'b0;

  logic a_ready, a_rv, a_re, a_twr, a_tsec, a_tusr;
  logic [DW-1:0] a_rd, a_twd;
  logic [NT-1:0] a_tv;
  logic [OW-1:0] a_taddr;
  logic [1:0]    a_tsz;
  logic [NT-1:0] a_trv = '0, a_tre = '0;
  logic [NT*DW-1:0] a_trd = '0;

  logic b_ready, b_rv, b_re, b_twr, b_tsec, b_tusr;
  logic [DW-1:0] b_rd, b_twd;
  logic [NT-1:0] b_tv;
  logic [OW-1:0] b_taddr;
  logic [1:0]    b_tsz;
  logic [NT*DW-1:0] b_trd;
  logic [NT-1:0] b_tre;
  assign b_trd = {64'h103, 64'h102, 64'h101, 64'h100};
  assign b_tre = '0;

  sysreg_router dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(a_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_size(req_size), .req_secure(req_secure), .req_user(req_user),
    .rsp_valid(a_rv), .rsp_rdata(a_rd), .rsp_err(a_re),
    .tgt_valid(a_tv), .tgt_addr(a_taddr), .tgt_write(a_twr), .tgt_wdata(a_twd),
    .tgt_size(a_tsz), .tgt_secure(a_tsec), .tgt_user(a_tusr),
    .tgt_rsp_valid(a_trv), .tgt_rsp_rdata(a_trd), .tgt_rsp_err(a_tre)
  );

  sysreg_router #(.SEC_EN(0), .RAS_EN(0)) dut2 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(b_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_size(req_size), .req_secure(req_secure), .req_user(req_user),
    .rsp_valid(b_rv), .rsp_rdata(b_rd), .rsp_err(b_re),
    .tgt_valid(b_tv), .tgt_addr(b_taddr), .tgt_write(b_twr), .tgt_wdata(b_twd),
    .tgt_size(b_tsz), .tgt_secure(b_tsec), .tgt_user(b_tusr),
    .tgt_rsp_valid(b_tv), .tgt_rsp_rdata(b_trd), .tgt_rsp_err(b_tre)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit inject = 1'b0;

  function automatic logic [63:0] mk_word(int k, logic [11:0] off, logic s,
                                          logic u, logic w, logic [1:0] sz);
    return {4'hA, 4'(k), 3'b0, s, 3'b0, u, 3'b0, w, 2'b0, sz, 4'h0, off, 24'hC0FFEE};
  endfunction

  // Behavioural target banks: target k answers k+1 cycles after its strobe
  int cnt[NT] = '{default: 0};
  logic [DW-1:0] word_q[NT];
  logic err_q[NT];
  always @(negedge clk) begin
    a_trv = '0;
    a_tre = '0;
    for (int k = 0; k < NT; k++) begin
      if (cnt[k] > 0) begin
        cnt[k] = cnt[k] - 1;
        if (cnt[k] == 0) begin
          a_trv[k] = 1'b1;
          a_tre[k] = err_q[k];
          a_trd[k*DW +: DW] = word_q[k];
        end
      end
    end
    for (int k = 0; k < NT; k++) begin
      if (a_tv[k]) begin
        cnt[k] = k + 1;
        word_q[k] = mk_word(k, a_taddr, a_tsec, a_tusr, a_twr, a_tsz);
        err_q[k] = a_tusr & a_twr;
        if (inject) begin
          a_trv[(k+1)%NT] = 1'b1;
          a_tre[(k+1)%NT] = 1'b1;
          a_trd[((k+1)%NT)*DW +: DW] = '1;
        end
      end
    end
  end

  // Reference routing from the requirements
  function automatic int route(logic [19:0] a, logic s, logic u, bit se, bit re,
                               output logic [11:0] off, output logic fs);
    fs = s;
    off = '0;
    if (a >= 20'h0E010 && a < 20'h0E0F0) begin
      off = 12'(a - 20'h0E010);
      return (se && s) ? 2 : 1;
    end
    if (re && a >= 20'h05000 && a < 20'h06000) begin
      off = 12'(a - 20'h05000);
      return 3;
    end
    if (a >= 20'h0E000 && a < 20'h0F000) begin
      off = 12'(a - 20'h0E000);
      return 0;
    end
    if (se && s && a >= 20'h2E000 && a < 20'h2F000) begin
      fs = 1'b0;
      if (a >= 20'h2E010 && a < 20'h2E0F0) begin
        off = 12'(a - 20'h2E010);
        return 1;
      end
      off = 12'(a - 20'h2E000);
      return 0;
    end
    return u ? BERR : RAZ;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic txn(string tag, logic [19:0] addr, logic wr, logic [1:0] sz,
                     logic s, logic u, bit spur);
    int ra, rb, a_at, b_at, a_n, b_n, a_tvc, b_tvc, a_rbad, b_rbad;
    logic [11:0] oa, ob;
    logic fa, fb, wd_bad, a_er, b_er;
    logic [NT-1:0] a_seen, b_seen;
    logic [63:0] wd, a_got, b_got, exp_a, exp_b;
    ra = route(addr, s, u, 1'b1, 1'b1, oa, fa);
    rb = route(addr, s, u, 1'b0, 1'b0, ob, fb);
    wd = {addr, 44'h0} ^ 64'h0123_4567_89AB_CDEF;
    a_at = -1; b_at = -1; a_n = 0; b_n = 0; a_tvc = 0; b_tvc = 0;
    a_rbad = 0; b_rbad = 0; wd_bad = 1'b0; a_seen = '0; b_seen = '0;
    a_got = '0; b_got = '0; a_er = 1'b0; b_er = 1'b0;
    @(negedge clk);
    inject = spur;
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_wdata = wd;
    req_size = sz; req_secure = s; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      if (a_tv != '0) begin
        a_tvc++; a_seen |= a_tv;
        if (a_twd != wd) wd_bad = 1'b1;
      end
      if (b_tv != '0) begin b_tvc++; b_seen |= b_tv; end
      if (a_rv) begin a_n++; if (a_at < 0) begin a_at = i; a_got = a_rd; a_er = a_re; end end
      if (b_rv) begin b_n++; if (b_at < 0) begin b_at = i; b_got = b_rd; b_er = b_re; end end
      if (a_ready != (a_at >= 0 && i > a_at)) a_rbad++;
      if (b_ready != (b_at >= 0 && i > b_at)) b_rbad++;
      @(negedge clk);
    end
    inject = 1'b0;
    // full-featured instance
    chk(a_seen == ((ra < 4) ? NT'(1) << ra : NT'(0)) && a_tvc == ((ra < 4) ? 1 : 0),
        tag, "target strobe", 64'(a_seen), (ra < 4) ? 64'(1) << ra : 64'(0));
    exp_a = (ra < 4) ? mk_word(ra, oa, fa, u, wr, sz) : 64'h0;
    chk(a_got == exp_a, tag, "read data", a_got, exp_a);
    chk(a_er == ((ra < 4) ? (u & wr) : (ra == BERR)), tag, "error bit",
        64'(a_er), (ra < 4) ? 64'(u & wr) : 64'(ra == BERR));
    chk(a_n == 1 && a_at == ((ra < 4) ? 3 + ra : 1), "R9", "response cycle",
        64'(a_at), (ra < 4) ? 64'(3 + ra) : 64'(1));
    if (ra < 4) chk(!wd_bad, "R9", "forwarded write data", 64'(wd_bad), 64'(0));
    chk(a_rbad == 0, "R10", "ready timing", 64'(a_rbad), 64'(0));
    // instance without security extension and RAS window
    chk(b_seen == ((rb < 4) ? NT'(1) << rb : NT'(0)) && b_tvc == ((rb < 4) ? 1 : 0),
        "R8", {tag, " target strobe (no-sec)"}, 64'(b_seen), (rb < 4) ? 64'(1) << rb : 64'(0));
    exp_b = (rb < 4) ? 64'h100 + 64'(rb) : 64'h0;
    chk(b_got == exp_b && b_er == (rb == BERR), "R8", {tag, " response (no-sec)"},
        b_got, exp_b);
    chk(b_n == 1 && b_at == ((rb < 4) ? 2 : 1) && b_rbad == 0, "R8",
        {tag, " timing (no-sec)"}, 64'(b_at), (rb < 4) ? 64'(2) : 64'(1));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(a_ready && !a_rv && a_tv == '0 && b_ready && !b_rv && b_tv == '0,
        "R1", "reset state", {a_ready, a_rv, 4'(a_tv)}, 6'b100000);

    txn("R2", 20'h0E010, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
    txn("R2", 20'h0E0EC, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    txn("R2", 20'h0E040, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0);
    txn("R3", 20'h0E0F0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
    txn("R3", 20'h0E00C, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
    txn("R3", 20'h0EFFC, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
    txn("R4", 20'h05000, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0);
    txn("R4", 20'h05FFF, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    txn("R4", 20'h06000, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
    txn("R5", 20'h00000, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
    txn("R5", 20'h00000, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0);
    txn("R5", 20'h01000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    txn("R5", 20'hFFFFF, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
    txn("R5", 20'h0DFFF, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
    txn("R6", 20'h2E010, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
    txn("R6", 20'h2E100, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0);
    txn("R6", 20'h2E0F0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
    txn("R7", 20'h2E000, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    txn("R7", 20'h2E020, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0);
    txn("R11", 20'h0E000, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1);
    txn("R11", 20'h0E050, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1);
    txn("R11", 20'h05010, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule